// File: doc/BRIEF.md
# Page-Entry Permission and Fault Classifier

This block judges one page-table entry against one memory access during an address translation. It takes the entry's 8-bit attribute byte, the kind of access (instruction fetch, load, store or atomic read-modify-write), the effective privilege, and two control bits. The first control bit lets loads read execute-only pages. The second lets supervisor code load from and store to user pages. The block decides whether the entry is malformed, whether it points to a further table level, and whether the access is allowed. It also decides whether the accessed or dirty bits have to be written back, and it produces the attribute byte with those bits set.

A page walker presents one entry per cycle with a strobe. It can also report two failures found outside this block: a memory error while fetching the entry, and a superpage whose physical number is not aligned to its level. The block picks the single failure that wins by priority, gives it a numeric failure code, and converts it into an exception cause number. That cause depends on whether the failure was a memory error and on the kind of access. The full result appears on registered outputs in the cycle after the strobe.

Top module: `pte_perm_classifier`

## Requirements
- R1: While reset is high, and in the cycle after it falls, res_valid is low and every result output is zero.
- R2: A result with res_valid high appears exactly one clock after a cycle with req_valid high. A cycle without req_valid produces res_valid low in the following cycle.
- R3: The attribute bit positions are D=7, A=6, G=5, U=4, X=3, W=2, R=1, V=0. An entry is invalid when V=0, or when W=1 with R=0. An invalid entry is never a pointer and is never granted.
- R4: A valid entry with R, W and X all zero is a pointer. For a pointer, res_grant and res_upd_need are 0 and res_new_attr equals the input byte.
- R5: With req_priv=0 (user), a leaf is granted only if U=1 and the access condition holds. Access kinds are 0 fetch, 1 load, 2 store, 3 read-modify-write. Fetch needs X. Load needs the read condition. Store needs W. Read-modify-write needs W and the read condition.
- R6: With req_priv=1 (supervisor), loads, stores and read-modify-writes need U=0, or U=1 with req_sum=1, plus the same access condition as in R5. A supervisor fetch needs U=0 and X=1, whatever req_sum is.
- R7: The read condition is R=1, or X=1 with req_mxr=1.
- R8: req_priv values 2 and 3 raise res_priv_err, and res_grant is then 0.
- R9: For a granted leaf, res_upd_need is 1 when A=0, or when the access kind is 2 or 3 and D=0. res_new_attr then equals the input with A set, and D also set for kinds 2 and 3. Otherwise res_new_attr equals the input.
- R10: When an update is needed, no misalignment is reported and req_upd_en=0, the result is a fault with code 5.
- R11: Fault codes are 1 memory error, 2 invalid entry, 3 no permission (a leaf that is not granted), 4 misaligned superpage (granted leaf only), and 5 update disabled. Priority runs in that order, 1 highest. res_fault is 1 exactly when res_fault_code is nonzero.
- R12: The cause for code 1 is 1 for fetch, 5 for load, and 7 for store or read-modify-write. The cause for codes 2 to 5 is 12 for fetch, 13 for load, and 15 for store or read-modify-write. res_cause is 0 when there is no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_attr | input | 8 | Attribute byte of the entry |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 read-modify-write |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 2/3 unsupported |
| req_mxr | input | 1 | Lets loads read execute-only pages |
| req_sum | input | 1 | Lets supervisor loads and stores reach user pages |
| req_upd_en | input | 1 | Hardware accessed/dirty update permitted |
| req_mem_err | input | 1 | Memory error while fetching the entry |
| req_misalign | input | 1 | Superpage physical number misaligned |
| res_valid | output | 1 | Result valid |
| res_invalid | output | 1 | Entry is invalid |
| res_pointer | output | 1 | Entry points to a next-level table |
| res_grant | output | 1 | Access permitted |
| res_upd_need | output | 1 | Accessed/dirty bits must be written |
| res_new_attr | output | 8 | Attribute byte after the update |
| res_priv_err | output | 1 | Unsupported privilege requested |
| res_fault | output | 1 | A failure is reported |
| res_fault_code | output | 3 | Winning failure code, 0 when none |
| res_cause | output | CAUSE_W | Exception cause number, 0 when none |

## Verification
Every attribute byte is swept against all four access kinds, all four privilege codes and every combination of the two control bits. This shows apart user and supervisor rights, the execute-only read override, the supervisor reach into user pages, and the rule that a supervisor may not fetch from a user page. While that sweep runs, the memory-error, misalignment and update-enable inputs change on different periods. Their overlaps therefore test the fault priority and the access-versus-page cause split for each access kind. Idle gaps between strobes show apart a real result from one that arrives too early or more than once.

// File: rtl/pte_cls_pkg.sv
package pte_cls_pkg;

  localparam int unsigned ATTR_W = 8;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned PRIV_W = 2;
  localparam int unsigned CODE_W = 3;

  localparam int unsigned B_V = 0;
  localparam int unsigned B_R = 1;
  localparam int unsigned B_W = 2;
  localparam int unsigned B_X = 3;
  localparam int unsigned B_U = 4;
  localparam int unsigned B_G = 5;
  localparam int unsigned B_A = 6;
  localparam int unsigned B_D = 7;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RMW   = 2'd3
  } kind_e;

  typedef enum logic [PRIV_W-1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [CODE_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_MEM    = 3'd1,
    FLT_BADPTE = 3'd2,
    FLT_DENY   = 3'd3,
    FLT_ALIGN  = 3'd4,
    FLT_ADUPD  = 3'd5
  } flt_e;

  function automatic logic kind_writes(kind_e k);
    return (k == KIND_STORE) || (k == KIND_RMW);
  endfunction

endpackage

// File: rtl/pte_entry_decode.sv
module pte_entry_decode
  import pte_cls_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output logic              is_invalid,
  output logic              is_pointer,
  output logic              is_leaf
);
  logic no_rwx;

  always_comb begin
    // Write-only pages are a reserved encoding and count as invalid.
    is_invalid = !attr[B_V] || (attr[B_W] && !attr[B_R]);
    no_rwx     = !(attr[B_R] || attr[B_W] || attr[B_X]);
    is_pointer = !is_invalid && no_rwx;
    is_leaf    = !is_invalid && !no_rwx;
  end
endmodule

// File: rtl/pte_access_rights.sv
module pte_access_rights
  import pte_cls_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  kind_e             kind,
  input  priv_e             priv,
  input  logic              mxr,
  input  logic              sum,
  output logic              rights_ok,
  output logic              priv_bad
);
  logic rd_cond;
  logic kind_cond;
  logic user_pg;

  always_comb begin
    user_pg = attr[B_U];
    rd_cond = attr[B_R] || (attr[B_X] && mxr);
    unique case (kind)
      KIND_FETCH: kind_cond = attr[B_X];
      KIND_LOAD:  kind_cond = rd_cond;
      KIND_STORE: kind_cond = attr[B_W];
      default:    kind_cond = attr[B_W] && rd_cond;
    endcase

    priv_bad  = 1'b0;
    rights_ok = 1'b0;
    unique case (priv)
      PRV_USER:  rights_ok = user_pg && kind_cond;
      PRV_SUPER: begin
        if (kind == KIND_FETCH) rights_ok = !user_pg && attr[B_X];
        else                    rights_ok = (!user_pg || sum) && kind_cond;
      end
      default:   priv_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pte_ad_update.sv
module pte_ad_update
  import pte_cls_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  logic              enable,
  input  kind_e             kind,
  output logic              need,
  output logic [ATTR_W-1:0] new_attr
);
  logic wr;
  logic set_d;

  always_comb begin
    wr       = kind_writes(kind);
    set_d    = wr && !attr[B_D];
    need     = enable && (!attr[B_A] || set_d);
    new_attr = attr;
    if (need) begin
      new_attr[B_A] = 1'b1;
      if (wr) new_attr[B_D] = 1'b1;
    end
  end
endmodule

// File: rtl/pte_cause_map.sv
module pte_cause_map
  import pte_cls_pkg::*;
#(
  parameter int unsigned CAUSE_W = 5
)(
  input  flt_e               code,
  input  kind_e              kind,
  output logic [CAUSE_W-1:0] cause
);
  localparam logic [CAUSE_W-1:0] C_FETCH_ACC = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_LOAD_ACC  = CAUSE_W'(5);
  localparam logic [CAUSE_W-1:0] C_STORE_ACC = CAUSE_W'(7);
  localparam logic [CAUSE_W-1:0] C_FETCH_PG  = CAUSE_W'(12);
  localparam logic [CAUSE_W-1:0] C_LOAD_PG   = CAUSE_W'(13);
  localparam logic [CAUSE_W-1:0] C_STORE_PG  = CAUSE_W'(15);

  always_comb begin
    cause = '0;
    if (code == FLT_MEM) begin
      unique case (kind)
        KIND_FETCH: cause = C_FETCH_ACC;
        KIND_LOAD:  cause = C_LOAD_ACC;
        default:    cause = C_STORE_ACC;
      endcase
    end else if (code != FLT_NONE) begin
      unique case (kind)
        KIND_FETCH: cause = C_FETCH_PG;
        KIND_LOAD:  cause = C_LOAD_PG;
        default:    cause = C_STORE_PG;
      endcase
    end
  end
endmodule

// File: rtl/pte_perm_classifier.sv
module pte_perm_classifier
  import pte_cls_pkg::*;
#(
  parameter int unsigned CAUSE_W = 5
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [7:0]         req_attr,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_priv,
  input  logic               req_mxr,
  input  logic               req_sum,
  input  logic               req_upd_en,
  input  logic               req_mem_err,
  input  logic               req_misalign,
  output logic               res_valid,
  output logic               res_invalid,
  output logic               res_pointer,
  output logic               res_grant,
  output logic               res_upd_need,
  output logic [7:0]         res_new_attr,
  output logic               res_priv_err,
  output logic               res_fault,
  output logic [2:0]         res_fault_code,
  output logic [CAUSE_W-1:0] res_cause
);
  kind_e kind;
  priv_e priv;
  logic  d_invalid, d_pointer, d_leaf;
  logic  r_ok, r_bad;
  logic  grant;
  logic  u_need;
  logic [ATTR_W-1:0] u_attr;
  flt_e  code;
  logic [CAUSE_W-1:0] cause;

  assign kind = kind_e'(req_kind);
  assign priv = priv_e'(req_priv);

  pte_entry_decode u_dec (
    .attr       (req_attr),
    .is_invalid (d_invalid),
    .is_pointer (d_pointer),
    .is_leaf    (d_leaf)
  );

  pte_access_rights u_rights (
    .attr      (req_attr),
    .kind      (kind),
    .priv      (priv),
    .mxr       (req_mxr),
    .sum       (req_sum),
    .rights_ok (r_ok),
    .priv_bad  (r_bad)
  );

  assign grant = d_leaf && r_ok;

  pte_ad_update u_ad (
    .attr     (req_attr),
    .enable   (grant),
    .kind     (kind),
    .need     (u_need),
    .new_attr (u_attr)
  );

  // Failure priority: memory, invalid, denied, misaligned, update blocked.
  always_comb begin
    code = FLT_NONE;
    if (req_mem_err)                  code = FLT_MEM;
    else if (d_invalid)               code = FLT_BADPTE;
    else if (d_leaf && !grant)        code = FLT_DENY;
    else if (grant && req_misalign)   code = FLT_ALIGN;
    else if (u_need && !req_upd_en)   code = FLT_ADUPD;
  end

  pte_cause_map #(.CAUSE_W(CAUSE_W)) u_cause (
    .code  (code),
    .kind  (kind),
    .cause (cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_invalid    <= 1'b0;
      res_pointer    <= 1'b0;
      res_grant      <= 1'b0;
      res_upd_need   <= 1'b0;
      res_new_attr   <= '0;
      res_priv_err   <= 1'b0;
      res_fault      <= 1'b0;
      res_fault_code <= '0;
      res_cause      <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_invalid    <= d_invalid;
        res_pointer    <= d_pointer;
        res_grant      <= grant;
        res_upd_need   <= u_need;
        res_new_attr   <= u_attr;
        res_priv_err   <= r_bad;
        res_fault      <= (code != FLT_NONE);
        res_fault_code <= code;
        res_cause      <= cause;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R2
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R2
  AST_INVALID_NOT_GRANTED: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_invalid |-> !res_grant && !res_pointer); // R3
  AST_POINTER_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_pointer |-> !res_upd_need && !res_grant); // R4
  AST_UNSUPPORTED_DENIED: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_priv_err |-> !res_grant); // R8
  AST_UPDATE_SETS_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_upd_need |-> res_new_attr[B_A]); // R9
  AST_MEM_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_mem_err |=> res_fault_code == 3'd1); // R11
  AST_NO_FAULT_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_fault |-> res_cause == '0 && res_fault_code == 3'd0); // R12

endmodule

// File: tb/pte_perm_classifier_tb_top.sv
`timescale 1ns/1ps
module pte_perm_classifier_tb_top;
  localparam int unsigned CW = 5;
  localparam int unsigned WATCHDOG_CYC = 150000;

  typedef struct packed {
    logic          invalid;
    logic          pointer;
    logic          grant;
    logic          upd_need;
    logic [7:0]    new_attr;
    logic          priv_err;
    logic          fault;
    logic [2:0]    code;
    logic [CW-1:0] cause;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_attr = '0;
  logic [1:0] req_kind = '0;
  logic [1:0] req_priv = '0;
  logic req_mxr = 1'b0, req_sum = 1'b0, req_upd_en = 1'b0;
  logic req_mem_err = 1'b0, req_misalign = 1'b0;
  logic res_valid, res_invalid, res_pointer, res_grant, res_upd_need;
  logic [7:0] res_new_attr;
  logic res_priv_err, res_fault;
  logic [2:0] res_fault_code;
  logic [CW-1:0] res_cause;

  int n_vec = 0;
  int n_bad = 0;
  exp_t sb_q[$];
  bit driver_done = 1'b0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  pte_perm_classifier #(.CAUSE_W(CW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_attr(req_attr),
    .req_kind(req_kind), .req_priv(req_priv), .req_mxr(req_mxr),
    .req_sum(req_sum), .req_upd_en(req_upd_en), .req_mem_err(req_mem_err),
    .req_misalign(req_misalign), .res_valid(res_valid),
    .res_invalid(res_invalid), .res_pointer(res_pointer),
    .res_grant(res_grant), .res_upd_need(res_upd_need),
    .res_new_attr(res_new_attr), .res_priv_err(res_priv_err),
    .res_fault(res_fault), .res_fault_code(res_fault_code),
    .res_cause(res_cause)
  );

  // Reference model written from the requirement text.
  function automatic exp_t model(logic [7:0] a, logic [1:0] k, logic [1:0] p,
                                 logic mxr, logic sum, logic upd_en,
                                 logic merr, logic mis);
    exp_t e;
    logic v, r, w, x, u, acc, dty, rd, need_k, ok, leaf, wr;
    v = a[0]; r = a[1]; w = a[2]; x = a[3]; u = a[4]; acc = a[6]; dty = a[7];
    e = '0;
    e.invalid = !v || (w && !r);                           // R3
    e.pointer = !e.invalid && !r && !w && !x;              // R4
    leaf = !e.invalid && !e.pointer;
    rd = r || (x && mxr);                                  // R7
    case (k)
      2'd0: need_k = x;
      2'd1: need_k = rd;
      2'd2: need_k = w;
      default: need_k = w && rd;
    endcase
    ok = 1'b0;
    if (p == 2'd0) ok = u && need_k;                       // R5
    else if (p == 2'd1) ok = (k == 2'd0) ? (!u && x) : ((!u || sum) && need_k); // R6
    else e.priv_err = 1'b1;                                // R8
    e.grant = leaf && ok;
    wr = k[1];
    e.upd_need = e.grant && (!acc || (wr && !dty));        // R9
    e.new_attr = a;
    if (e.upd_need) begin
      e.new_attr[6] = 1'b1;
      if (wr) e.new_attr[7] = 1'b1;
    end
    if (merr) e.code = 3'd1;                               // R11
    else if (e.invalid) e.code = 3'd2;
    else if (leaf && !e.grant) e.code = 3'd3;
    else if (e.grant && mis) e.code = 3'd4;
    else if (e.upd_need && !upd_en) e.code = 3'd5;         // R10
    e.fault = (e.code != 3'd0);
    if (e.code == 3'd1) e.cause = (k == 2'd0) ? CW'(1) : (k == 2'd1) ? CW'(5) : CW'(7); // R12
    else if (e.fault) e.cause = (k == 2'd0) ? CW'(12) : (k == 2'd1) ? CW'(13) : CW'(15);
    return e;
  endfunction

  task automatic apply(logic [7:0] a, logic [1:0] k, logic [1:0] p, logic mxr,
                       logic sum, logic upd_en, logic merr, logic mis);
    @(negedge clk);
    req_valid = 1'b1; req_attr = a; req_kind = k; req_priv = p;
    req_mxr = mxr; req_sum = sum; req_upd_en = upd_en;
    req_mem_err = merr; req_misalign = mis;
    sb_q.push_back(model(a, k, p, mxr, sum, upd_en, merr, mis));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops one expectation per result.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && res_valid) begin
        exp_t e;
        bit bad;
        n_vec++;
        bad = 1'b0;
        if (sb_q.size() == 0) begin
          $display("FAIL R2: result without request (res_valid=1 expected 0)");
          bad = 1'b1;
        end else begin
          e = sb_q.pop_front();
          if (res_invalid !== e.invalid) begin bad = 1'b1;
            $display("FAIL R3: invalid act=%0b exp=%0b attr", res_invalid, e.invalid); end
          if (res_pointer !== e.pointer) begin bad = 1'b1;
            $display("FAIL R4: pointer act=%0b exp=%0b", res_pointer, e.pointer); end
          if (res_grant !== e.grant) begin bad = 1'b1;
            $display("FAIL R5/R6: grant act=%0b exp=%0b", res_grant, e.grant); end
          if (res_priv_err !== e.priv_err) begin bad = 1'b1;
            $display("FAIL R8: priv_err act=%0b exp=%0b", res_priv_err, e.priv_err); end
          if (res_upd_need !== e.upd_need || res_new_attr !== e.new_attr) begin bad = 1'b1;
            $display("FAIL R9: upd=%0b attr=%h exp upd=%0b attr=%h",
                     res_upd_need, res_new_attr, e.upd_need, e.new_attr); end
          if (res_fault !== e.fault || res_fault_code !== e.code) begin bad = 1'b1;
            $display("FAIL R11: fault=%0b code=%0d exp fault=%0b code=%0d",
                     res_fault, res_fault_code, e.fault, e.code); end
          if (res_cause !== e.cause) begin bad = 1'b1;
            $display("FAIL R12: cause act=%0d exp=%0d", res_cause, e.cause); end
        end
        if (bad) n_bad++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!driver_done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (act=hung exp=done)");
      report();
    end
  end

  initial begin
    int cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0 || res_fault !== 1'b0 || res_cause !== '0 || res_new_attr !== '0) begin
      n_bad++;
      $display("FAIL R1: reset outputs valid=%0b fault=%0b cause=%0d attr=%h exp all 0",
               res_valid, res_fault, res_cause, res_new_attr);
    end
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: res_valid after reset act=%0b exp=0", res_valid);
    end

    // Directed corners
    apply(8'h1B, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R6: sup load on user page, no sum -> deny
    apply(8'h1B, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R6: with sum -> grant
    apply(8'hDB, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R6: sup fetch user page denied even with sum
    apply(8'h49, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5: user load of X-only page denied
    apply(8'h59, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7: mxr lets it read
    apply(8'h17, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R10: store needs A and D, update off
    idle();                                                 // R2: gap
    apply(8'h17, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R9: rmw sets A and D
    apply(8'h05, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R3: W without R invalid
    apply(8'h01, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R4: pointer
    apply(8'h4B, 2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R8: machine requested
    apply(8'h4B, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1); // R11/R12: mem error wins, fetch access
    apply(8'h4B, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R11: misaligned -> load page fault
    idle(); idle();

    // Sweep: all attributes x kinds x privileges x control bits
    cnt = 0;
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 4; p++) begin
          for (int c = 0; c < 4; c++) begin
            apply(a[7:0], k[1:0], p[1:0], c[0], c[1],
                  cnt[3] ^ cnt[0], (cnt % 13) == 0, (cnt % 7) == 3);
            cnt++;
            if ((cnt % 97) == 0) idle();
          end
        end
      end
    end
    idle(); idle(); idle();
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d results missing (act=%0d exp=0)", sb_q.size(), sb_q.size());
    end
    driver_done = 1'b1;
    report();
  end
endmodule